// File: doc/BRIEF.md
# Serial ADC Host-Port Front End

This block is the digital serial front end of a multi-channel converter with a 10-bit result. A host frames each transfer with an active-low chip select and clocks it with a serial clock. During one frame the host shifts in a 4-bit channel number on a serial address line. At the same time it reads the result of the previous conversion from a serial data output. The data output behaves as a three-state pin, modelled here as a data bit plus an output enable.

The serial clock, chip select and address line are synchronised into a faster system clock. Edges are found in that domain and counted there. Counting falling serial-clock edges, the block opens a sampling window for the selected channel and then hands a start pulse to the converter core. It also holds an end-of-conversion flag low until the core returns a new result with a done strobe. The parallel side carries the channel select, the sampling window, the start pulse and the returned result. The analog core lies outside the block.

Top module: `adc_serial_front`

## Requirements
- R1: After a synchronous reset: `dout_en` is 0, `eoc` is 1, `conv_start` and `sample_en` are 0, `chan_sel` is 0, and the stored result is 0.
- R2: While `cs_n` is high, `dout_en` is 0. Serial-clock and address activity then has no effect: `chan_sel` does not change, no `conv_start` is issued, and the next frame still starts at bit 9 of the stored result.
- R3: The channel number is taken MSB first from `addr_in` on the first four rising `sclk` edges of a frame. `chan_sel` shows it after the fourth rising edge. Later address bits in the frame are ignored.
- R4: After `cs_n` falls, `dout_en` is 1 and `dout` carries bit 9 of the stored result. Falling `sclk` edge k (k = 1..9) presents bit 9-k, so bit 0 appears on the ninth falling edge.
- R5: From the tenth falling edge onward, `dout` is 0 for the rest of the frame, for frames of up to 16 clocks.
- R6: `sample_en` goes high on the fourth falling `sclk` edge and low on the tenth.
- R7: On the tenth falling edge, `conv_start` pulses for exactly one system cycle and `eoc` goes low. `eoc` returns high only after `res_valid`.
- R8: A result presented with `res_valid` is stored. The next frame shifts it out.
- R9: If `cs_n` rises before the tenth falling edge, the frame aborts: there is no `conv_start`, `eoc` stays high, `sample_en` clears, and the stored result is unchanged.
- R10: Frames of any length from 10 to 16 serial clocks perform one conversion each.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than sclk |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low chip select (asynchronous) |
| sclk | input | 1 | Serial clock (asynchronous) |
| addr_in | input | 1 | Serial channel address, MSB first |
| dout | output | 1 | Serial result bit |
| dout_en | output | 1 | Output enable of the serial result (0 = high impedance) |
| eoc | output | 1 | End of conversion, low while a conversion is pending |
| chan_sel | output | 4 | Selected channel for the analog multiplexer |
| sample_en | output | 1 | Sampling window for the selected channel |
| conv_start | output | 1 | One-cycle request to the converter core |
| res_data | input | 10 | Result from the converter core |
| res_valid | input | 1 | Strobe marking res_data valid |

## Verification
The bench targets the edge-count boundaries, where an off-by-one shows up directly. A shifter that is early or late would return bit 0 on the eighth or tenth falling edge, or would stop padding with zeros after edge ten in a 16-clock frame. The bench also runs a frame that is cut short after six clocks. A design that starts converting anyway would drop `eoc` and replace the stored result. Finally, the bench toggles the serial clock with chip select high and drives address bits after the fourth clock. A design that listens at those times would move `chan_sel` or skip bits of the next read-out.

// File: rtl/adc_serial_pkg.sv
package adc_serial_pkg;
  localparam int RES_W      = 10;
  localparam int ADDR_W     = 4;
  localparam int SAMPLE_EDG = 4;
  localparam int CONV_EDG   = RES_W;
  localparam int CNT_W      = 5;
  typedef logic [RES_W-1:0]  res_t;
  typedef logic [ADDR_W-1:0] addr_t;
endpackage

// File: rtl/adc_serial_sync.sv
module adc_serial_sync #(
  parameter int W = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] q,
  output logic [W-1:0] q_prev
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
      q_prev <= RST_VAL;
    end else begin
      stg[0] <= d_in;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
      q_prev <= stg[STAGES-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/adc_serial_frame.sv
module adc_serial_frame
  import adc_serial_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  cs_s,
  input  logic  cs_prev,
  input  logic  sclk_s,
  input  logic  sclk_prev,
  input  logic  addr_s,
  input  res_t  stored,
  output logic  dout,
  output logic  dout_en,
  output addr_t chan_sel,
  output logic  sample_en,
  output logic  conv_start
);
  localparam logic [CNT_W-1:0] SAMP_AT = CNT_W'(SAMPLE_EDG);
  localparam logic [CNT_W-1:0] CONV_AT = CNT_W'(CONV_EDG);
  localparam logic [CNT_W-1:0] RISE_LAST = CNT_W'(ADDR_W - 1);
  localparam logic [CNT_W-1:0] RISE_LIM = CNT_W'(ADDR_W);

  logic [CNT_W-1:0] rise_cnt, fall_cnt, fall_nxt;
  addr_t addr_sr, addr_nxt;
  res_t  shreg;
  logic  active, cs_fall, rise, fall;

  assign active   = ~cs_s;
  assign cs_fall  = cs_prev & ~cs_s;
  assign rise     = active & ~sclk_prev & sclk_s;
  assign fall     = active & sclk_prev & ~sclk_s;
  assign fall_nxt = (fall_cnt == '1) ? fall_cnt : fall_cnt + 1'b1;
  assign addr_nxt = {addr_sr[ADDR_W-2:0], addr_s};

  always_ff @(posedge clk) begin
    if (rst) begin
      rise_cnt   <= '0;
      fall_cnt   <= '0;
      addr_sr    <= '0;
      shreg      <= '0;
      chan_sel   <= '0;
      dout       <= 1'b0;
      dout_en    <= 1'b0;
      sample_en  <= 1'b0;
      conv_start <= 1'b0;
    end else begin
      conv_start <= 1'b0;
      dout_en    <= active;
      if (cs_fall) begin
        rise_cnt  <= '0;
        fall_cnt  <= '0;
        addr_sr   <= '0;
        shreg     <= {stored[RES_W-2:0], 1'b0};
        dout      <= stored[RES_W-1];
        sample_en <= 1'b0;
      end else if (!active) begin
        sample_en <= 1'b0;
        dout      <= 1'b0;
      end else begin
        if (rise && rise_cnt < RISE_LIM) begin
          addr_sr  <= addr_nxt;
          rise_cnt <= rise_cnt + 1'b1;
          if (rise_cnt == RISE_LAST) chan_sel <= addr_nxt;
        end
        if (fall) begin
          dout     <= shreg[RES_W-1];
          shreg    <= {shreg[RES_W-2:0], 1'b0};
          fall_cnt <= fall_nxt;
          if (fall_nxt == SAMP_AT) sample_en <= 1'b1;
          if (fall_nxt == CONV_AT && fall_cnt != CONV_AT) begin
            sample_en  <= 1'b0;
            conv_start <= 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/adc_serial_result.sv
module adc_serial_result
  import adc_serial_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic conv_start,
  input  logic res_valid,
  input  res_t res_data,
  output res_t stored,
  output logic eoc
);
  always_ff @(posedge clk) begin
    if (rst) begin
      stored <= '0;
      eoc    <= 1'b1;
    end else begin
      if (res_valid) stored <= res_data;
      if (conv_start) eoc <= 1'b0;
      else if (res_valid) eoc <= 1'b1;
    end
  end
endmodule

// File: rtl/adc_serial_front.sv
module adc_serial_front
  import adc_serial_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic              addr_in,
  output logic              dout,
  output logic              dout_en,
  output logic              eoc,
  output logic [ADDR_W-1:0] chan_sel,
  output logic              sample_en,
  output logic              conv_start,
  input  logic [RES_W-1:0]  res_data,
  input  logic              res_valid
);
  logic [2:0] raw_in, syn, syn_prev;
  res_t stored;

  assign raw_in = {cs_n, sclk, addr_in};

  adc_serial_sync #(.W(3), .STAGES(2), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst(rst), .d_in(raw_in), .q(syn), .q_prev(syn_prev)
  );

  adc_serial_frame u_frame (
    .clk(clk), .rst(rst),
    .cs_s(syn[2]), .cs_prev(syn_prev[2]),
    .sclk_s(syn[1]), .sclk_prev(syn_prev[1]),
    .addr_s(syn[0]), .stored(stored),
    .dout(dout), .dout_en(dout_en), .chan_sel(chan_sel),
    .sample_en(sample_en), .conv_start(conv_start)
  );

  adc_serial_result u_res (
    .clk(clk), .rst(rst), .conv_start(conv_start),
    .res_valid(res_valid), .res_data(res_data),
    .stored(stored), .eoc(eoc)
  );
endmodule

// File: rtl/adc_serial_front_chk.sv
module adc_serial_front_chk (
  input logic clk,
  input logic rst,
  input logic cs_n,
  input logic dout_en,
  input logic eoc,
  input logic sample_en,
  input logic conv_start,
  input logic res_valid
);
  logic [2:0] since_rst;
  always_ff @(posedge clk) begin
    if (rst) since_rst <= '0;
    else if (since_rst != 3'd7) since_rst <= since_rst + 1'b1;
  end

  // R1: leaving reset the flags are idle
  assert_reset_idle_R1: assert property (@(posedge clk) disable iff (rst)
    (since_rst == 3'd0) |-> (eoc && !conv_start && !dout_en && !sample_en));

  // R2: chip select held high keeps the output released
  assert_released_R2: assert property (@(posedge clk) disable iff (rst)
    (since_rst >= 3'd4 && $past(cs_n, 1) && $past(cs_n, 2) && $past(cs_n, 3)) |-> !dout_en);

  // R6: a start is preceded by an open sampling window
  assert_sampled_first_R6: assert property (@(posedge clk) disable iff (rst)
    (conv_start && since_rst >= 3'd1) |-> $past(sample_en));

  // R7: single-cycle start that drops end-of-conversion
  assert_start_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    conv_start |=> (!conv_start && !eoc));

  // R7: end-of-conversion only rises after a done strobe
  assert_eoc_rise_R7: assert property (@(posedge clk) disable iff (rst)
    (since_rst >= 3'd1 && $rose(eoc)) |-> $past(res_valid));
endmodule

bind adc_serial_front adc_serial_front_chk u_chk (
  .clk(clk), .rst(rst), .cs_n(cs_n), .dout_en(dout_en), .eoc(eoc),
  .sample_en(sample_en), .conv_start(conv_start), .res_valid(res_valid)
);

// File: tb/adc_serial_front_test.sv
`timescale 1ns/1ps
module adc_serial_front_test;
  localparam int HALF = 8;
  localparam int DELAY = 120;
  localparam int NV = 6;
  // {addr[3:0], result[9:0], clocks[4:0]}
  localparam logic [18:0] VEC [NV] = '{
    {4'hA, 10'h2B5, 5'd10}, {4'h3, 10'h3FF, 5'd16}, {4'h0, 10'h001, 5'd12},
    {4'hF, 10'h200, 5'd11}, {4'h6, 10'h155, 5'd14}, {4'h9, 10'h0AA, 5'd13}};

  logic clk = 0, rst = 1, cs_n = 1, sclk = 0, addr_in = 0;
  logic dout, dout_en, eoc, sample_en, conv_start;
  logic [3:0] chan_sel;
  logic [9:0] res_data = '0, stub_val = '0;
  logic res_valid = 0;
  int busy = 0, starts = 0, checks = 0, fails = 0;
  logic [9:0] exp_prev = '0;

  always #2 clk = ~clk;

  adc_serial_front uut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .addr_in(addr_in),
    .dout(dout), .dout_en(dout_en), .eoc(eoc), .chan_sel(chan_sel),
    .sample_en(sample_en), .conv_start(conv_start),
    .res_data(res_data), .res_valid(res_valid)
  );

  // converter core stand-in with a fixed delay
  always @(posedge clk) begin
    res_valid <= 1'b0;
    if (conv_start) begin
      busy <= DELAY;
      starts <= starts + 1;
    end else if (busy != 0) begin
      busy <= busy - 1;
      if (busy == 1) begin
        res_valid <= 1'b1;
        res_data  <= stub_val;
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic frame(input logic [3:0] a, input logic [9:0] r, input int n);
    int s0;
    s0 = starts;
    stub_val = r;
    cs_n = 0;
    tick(HALF);
    check("R4 enable", dout_en, 1);
    check("R4 msb", dout, exp_prev[9]);
    for (int i = 1; i <= n; i++) begin
      addr_in = (i <= 4) ? a[4-i] : ~a[i % 4];
      tick(2);
      sclk = 1;
      tick(HALF - 2);
      sclk = 0;
      tick(HALF);
      if (i <= 9) check("R4 bit", dout, exp_prev[9-i]);
      else check("R5 pad", dout, 0);
      check("R6 window", sample_en, (i >= 4 && i < 10));
      if (i == 4) check("R3 chan", chan_sel, a);
      if (i == 10) begin
        check("R7 start", starts, s0 + 1);
        check("R7 eoc low", eoc, 0);
      end
    end
    cs_n = 1;
    tick(HALF);
    check("R2 released", dout_en, 0);
    check("R3 late addr ignored", chan_sel, a);
    if (n >= 10) begin
      for (int k = 0; k < 400 && !eoc; k++) tick(1);
      check("R7 eoc back", eoc, 1);
      check("R10 one start", starts, s0 + 1);
      exp_prev = r;
    end else begin
      tick(DELAY + 20);
      check("R9 no start", starts, s0);
      check("R9 eoc high", eoc, 1);
      check("R9 window shut", sample_en, 0);
    end
  endtask

  initial begin
    int s0;
    tick(5);
    rst = 0;
    tick(2);
    check("R1 enable", dout_en, 0);
    check("R1 eoc", eoc, 1);
    check("R1 start", conv_start, 0);
    check("R1 window", sample_en, 0);
    check("R1 chan", chan_sel, 0);

    for (int v = 0; v < NV; v++)
      frame(VEC[v][18:15], VEC[v][14:5], int'(VEC[v][4:0]));

    // R2: clocks and address with chip select high
    s0 = starts;
    addr_in = 1;
    for (int i = 0; i < 12; i++) begin
      sclk = 1; tick(HALF);
      sclk = 0; tick(HALF);
      addr_in = ~addr_in;
    end
    check("R2 chan kept", chan_sel, VEC[NV-1][18:15]);
    check("R2 no start", starts, s0);
    check("R2 released", dout_en, 0);

    // R9: aborted frame, then R8 read-back of unchanged result
    frame(4'h5, 10'h3C3, 6);
    frame(4'h2, 10'h111, 10);
    frame(4'h7, 10'h0F0, 16);
    check("R8 stored", exp_prev, 10'h0F0);

    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule